// File: doc/BRIEF.md
# Remapping engine global command and status controller

This block is the register-facing control unit of an address and interrupt remapping engine. Software issues commands by writing a 32-bit command word. The word must equal the current status word with exactly one command bit flipped. Two kinds of command bits exist. The table-pointer bits are one-shot bits: they copy a staged 64-bit table address into the active configuration in the cycle that follows the write, and they never appear in status. The three enable bits are persistent: queued invalidation, DMA remapping and interrupt remapping. A change to one of them starts a completion countdown of programmable length. Only when the countdown ends does the status register take the new value, and software polls status until it does.

Two staged address pairs are held in the block, one for the translation root table and one for the interrupt table. The low 12 bits of each address are dropped when it is latched. The low four bits of the interrupt table address are kept apart as a size code. A read-only identification word carries a major and a minor revision. Re-pointing a table while its function is enabled is allowed, and it raises a one-cycle pulse that tells the engine to flush cached state.

Top module: `remap_gcmd_ctrl`

## Requirements
- R1: After reset the status word, all three enable outputs, both active pointers, the size code, `inval_req` and `cmd_err` are zero.
- R2: Register address 0 reads `{major[3:0], minor[2:0]}` in bits 6:0, where major is at least 1. Writes to address 0 do not change what it reads.
- R3: A command write (address 1) is rejected when the number of bits in which it differs from status is not exactly one. It is also rejected when that one bit is not one of the command bits 0, 1, 2, 4 or 5. A rejected write raises `cmd_err` for exactly the one cycle after the write and changes neither status nor pointers.
- R4: Command bit 4 copies `{addr 4, addr 3}` with bits 11:0 cleared into `root_ptr` one cycle after the write. Status bits 5:4 always read as zero.
- R5: Command bit 5 copies `{addr 6, addr 5}` with bits 11:0 cleared into `irt_ptr`, and copies bits 3:0 of address 5 into `irt_size`, one cycle after the write.
- R6: Setting persistent bit 0 (queued invalidation), bit 1 (DMA remapping) or bit 2 (interrupt remapping) shows in status (address 2) exactly D+1 cycles after the write edge, where D is the delay register, and not before.
- R7: Clearing a persistent bit clears its status bit after the same D+1 cycles.
- R8: `qi_en`, `dma_en` and `intr_en` equal status bits 0, 1 and 2.
- R9: A command write accepted while a completion is still pending is rejected as in R3, and the pending change still completes.
- R10: A root latch while DMA remapping is enabled, or an interrupt table latch while interrupt remapping is enabled, still updates the pointer and pulses `inval_req` for the one cycle after the write. The same latch while the function is disabled leaves `inval_req` low.
- R11: Writes to the staged address registers do not change the active pointers until a latch command is issued.
- R12: The delay register (address 7) is writable, reads back its low DLY_W bits, and resets to the DLY_RESET parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| qi_en | output | 1 | Queued invalidation enabled |
| dma_en | output | 1 | DMA remapping enabled |
| intr_en | output | 1 | Interrupt remapping enabled |
| root_ptr | output | 64 | Active root table address |
| irt_ptr | output | 64 | Active interrupt table address |
| irt_size | output | 4 | Active interrupt table size code |
| inval_req | output | 1 | One-cycle request to flush cached translations |
| cmd_err | output | 1 | One-cycle pulse for a rejected command write |

## Verification
A corrupted countdown or pending flag shows first in the latency of a status change. The bench therefore measures that latency for every enable bit, in both directions, over a range of delays, and an error of even one cycle is seen at the status read. A decoder that classifies a write wrongly shows in the cycle right after the write, as a missing or extra `cmd_err`, a moved pointer or a stray `inval_req`. The pointer paths are swept with several address patterns, so a masking or staging fault shows on the next latch.

// File: rtl/remap_gcmd_pkg.sv
package remap_gcmd_pkg;

   localparam int unsigned NUM_EN   = 3;
   localparam int unsigned BIT_QI   = 0;
   localparam int unsigned BIT_DMA  = 1;
   localparam int unsigned BIT_INTR = 2;
   localparam int unsigned BIT_ROOT = 4;
   localparam int unsigned BIT_IRT  = 5;

   typedef enum logic [2:0] {
      RA_VER     = 3'd0,
      RA_CMD     = 3'd1,
      RA_STS     = 3'd2,
      RA_ROOT_LO = 3'd3,
      RA_ROOT_HI = 3'd4,
      RA_IRT_LO  = 3'd5,
      RA_IRT_HI  = 3'd6,
      RA_DLY     = 3'd7
   } reg_addr_e;

endpackage

// File: rtl/remap_cmd_decode.sv
module remap_cmd_decode
   import remap_gcmd_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              cmd_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] sts_word,
   input  logic              busy,
   output logic              accept,
   output logic              reject,
   output logic              latch_root,
   output logic              latch_irt,
   output logic              en_go,
   output logic [1:0]        en_idx,
   output logic              en_val
);

   localparam logic [DATA_W-1:0] LEGAL_MASK =
      DATA_W'((1 << BIT_QI) | (1 << BIT_DMA) | (1 << BIT_INTR) |
              (1 << BIT_ROOT) | (1 << BIT_IRT));

   logic [DATA_W-1:0] diff;
   logic              single;

   assign diff   = wdata ^ sts_word;
   assign single = ($countones(diff) == 1) && ((diff & ~LEGAL_MASK) == '0);
   assign accept = cmd_we && single && !busy;
   assign reject = cmd_we && !accept;

   assign latch_root = accept && diff[BIT_ROOT];
   assign latch_irt  = accept && diff[BIT_IRT];

   always_comb begin
      en_go  = 1'b0;
      en_idx = '0;
      for (int i = 0; i < int'(NUM_EN); i++) begin
         if (diff[i]) begin
            en_go  = accept;
            en_idx = 2'(i);
         end
      end
      en_val = wdata[en_idx];
   end

endmodule

// File: rtl/remap_done_timer.sv
module remap_done_timer #(
   parameter int unsigned DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DLY_W-1:0] delay,
   output logic             busy,
   output logic             fire
);

   logic [DLY_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (start) begin
         cnt_q  <= delay;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == '0) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign busy = busy_q;
   assign fire = busy_q && (cnt_q == '0);

endmodule

// File: rtl/remap_ptr_latch.sv
module remap_ptr_latch #(
   parameter int unsigned ADDR_W     = 64,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter bit          HAS_SIZE   = 1'b0,
   parameter int unsigned SIZE_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] src,
   output logic [ADDR_W-1:0] ptr_o,
   output logic [SIZE_W-1:0] size_o
);

   localparam int unsigned KEEP_W = ADDR_W - PAGE_SHIFT;

   logic [KEEP_W-1:0] page_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= '0;
      end else if (load) begin
         page_q <= src[ADDR_W-1:PAGE_SHIFT];
      end
   end

   assign ptr_o = {page_q, {PAGE_SHIFT{1'b0}}};

   generate
      if (HAS_SIZE) begin : g_size
         logic [SIZE_W-1:0] size_q;
         logic [PAGE_SHIFT-SIZE_W-1:0] unused_mid;
         assign unused_mid = src[PAGE_SHIFT-1:SIZE_W];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               size_q <= '0;
            end else if (load) begin
               size_q <= src[SIZE_W-1:0];
            end
         end
         assign size_o = size_q;
      end else begin : g_nosize
         logic [PAGE_SHIFT-1:0] unused_low;
         assign unused_low = src[PAGE_SHIFT-1:0];
         assign size_o     = '0;
      end
   endgenerate

endmodule

// File: rtl/remap_gcmd_ctrl.sv
module remap_gcmd_ctrl
   import remap_gcmd_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned DLY_W      = 8,
   parameter int unsigned DLY_RESET  = 4,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned SIZE_W     = 4,
   parameter int unsigned VER_MAJOR  = 1,
   parameter int unsigned VER_MINOR  = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [2:0]          wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [2:0]          rd_addr,
   output logic [DATA_W-1:0]   rd_data,
   output logic                qi_en,
   output logic                dma_en,
   output logic                intr_en,
   output logic [2*DATA_W-1:0] root_ptr,
   output logic [2*DATA_W-1:0] irt_ptr,
   output logic [SIZE_W-1:0]   irt_size,
   output logic                inval_req,
   output logic                cmd_err
);

   localparam int unsigned ADDR_W = 2 * DATA_W;
   localparam logic [DATA_W-1:0] VER_WORD =
      DATA_W'((VER_MAJOR << 3) | VER_MINOR);

   generate
      if (DATA_W != 32) begin : g_bad_w
         $error("DATA_W must be 32");
      end
      if (VER_MAJOR < 1 || VER_MAJOR > 15) begin : g_bad_maj
         $error("VER_MAJOR must lie in 1..15");
      end
      if (VER_MINOR > 7) begin : g_bad_min
         $error("VER_MINOR must fit three bits");
      end
      if (DLY_W < 1 || DLY_W > DATA_W) begin : g_bad_dly
         $error("DLY_W out of range");
      end
      if (DLY_RESET >= (1 << DLY_W)) begin : g_bad_rst
         $error("DLY_RESET does not fit DLY_W");
      end
      if (SIZE_W >= PAGE_SHIFT) begin : g_bad_size
         $error("SIZE_W must be below PAGE_SHIFT");
      end
   endgenerate

   logic [DATA_W-1:0] root_lo_q, root_hi_q, irt_lo_q, irt_hi_q;
   logic [DLY_W-1:0]  dly_q;
   logic [NUM_EN-1:0] sts_q;
   logic [1:0]        pend_idx_q;
   logic              pend_val_q;
   logic              inval_q, err_q;

   logic [DATA_W-1:0] sts_word;
   logic              cmd_we, accept, reject;
   logic              latch_root, latch_irt, en_go, en_val;
   logic [1:0]        en_idx;
   logic              tmr_busy, tmr_fire;
   logic              unused_accept;
   logic [SIZE_W-1:0] unused_root_size;

   assign sts_word = DATA_W'(sts_q);
   assign cmd_we   = wr_en && (wr_addr == RA_CMD);

   remap_cmd_decode #(.DATA_W(DATA_W)) u_dec (
      .cmd_we     (cmd_we),
      .wdata      (wr_data),
      .sts_word   (sts_word),
      .busy       (tmr_busy),
      .accept     (accept),
      .reject     (reject),
      .latch_root (latch_root),
      .latch_irt  (latch_irt),
      .en_go      (en_go),
      .en_idx     (en_idx),
      .en_val     (en_val)
   );
   assign unused_accept = accept;

   remap_done_timer #(.DLY_W(DLY_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (en_go),
      .delay (dly_q),
      .busy  (tmr_busy),
      .fire  (tmr_fire)
   );

   remap_ptr_latch #(
      .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .HAS_SIZE(1'b0), .SIZE_W(SIZE_W)
   ) u_root (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (latch_root),
      .src    ({root_hi_q, root_lo_q}),
      .ptr_o  (root_ptr),
      .size_o (unused_root_size)
   );

   remap_ptr_latch #(
      .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .HAS_SIZE(1'b1), .SIZE_W(SIZE_W)
   ) u_irt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (latch_irt),
      .src    ({irt_hi_q, irt_lo_q}),
      .ptr_o  (irt_ptr),
      .size_o (irt_size)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         root_lo_q <= '0;
         root_hi_q <= '0;
         irt_lo_q  <= '0;
         irt_hi_q  <= '0;
         dly_q     <= DLY_W'(DLY_RESET);
      end else if (wr_en) begin
         case (wr_addr)
            RA_ROOT_LO: root_lo_q <= wr_data;
            RA_ROOT_HI: root_hi_q <= wr_data;
            RA_IRT_LO:  irt_lo_q  <= wr_data;
            RA_IRT_HI:  irt_hi_q  <= wr_data;
            RA_DLY:     dly_q     <= wr_data[DLY_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q      <= '0;
         pend_idx_q <= '0;
         pend_val_q <= 1'b0;
      end else begin
         if (en_go) begin
            pend_idx_q <= en_idx;
            pend_val_q <= en_val;
         end
         if (tmr_fire) begin
            sts_q[pend_idx_q] <= pend_val_q;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inval_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         inval_q <= (latch_root && sts_q[BIT_DMA]) || (latch_irt && sts_q[BIT_INTR]);
         err_q   <= reject;
      end
   end

   always_comb begin
      case (rd_addr)
         RA_VER:     rd_data = VER_WORD;
         RA_STS:     rd_data = sts_word;
         RA_ROOT_LO: rd_data = root_lo_q;
         RA_ROOT_HI: rd_data = root_hi_q;
         RA_IRT_LO:  rd_data = irt_lo_q;
         RA_IRT_HI:  rd_data = irt_hi_q;
         RA_DLY:     rd_data = DATA_W'(dly_q);
         default:    rd_data = '0;
      endcase
   end

   assign qi_en     = sts_q[BIT_QI];
   assign dma_en    = sts_q[BIT_DMA];
   assign intr_en   = sts_q[BIT_INTR];
   assign inval_req = inval_q;
   assign cmd_err   = err_q;

endmodule

// File: rtl/remap_gcmd_chk.sv
module remap_gcmd_chk
   import remap_gcmd_pkg::*;
#(
   parameter int unsigned ADDR_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [2:0]        wr_addr,
   input logic              cmd_err,
   input logic              inval_req,
   input logic              dma_en,
   input logic [ADDR_W-1:0] root_ptr,
   input logic [ADDR_W-1:0] irt_ptr,
   input logic [NUM_EN-1:0] sts,
   input logic              busy
);

   AST_ERR_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> $past(wr_en && wr_addr == RA_CMD)); // R3

   AST_ERR_KEEPS_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> ($stable(root_ptr) && $stable(irt_ptr))); // R3

   AST_STS_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sts) |-> $past(busy)); // R6

   AST_EN_RISE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_en) |-> $past(busy)); // R8

   AST_BUSY_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en && wr_addr == RA_CMD) |=> cmd_err); // R9

   AST_INVAL_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      inval_req |-> $past(wr_en && wr_addr == RA_CMD)); // R10

   AST_PTR_MOVES_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(root_ptr) || !$stable(irt_ptr)) |-> $past(wr_en && wr_addr == RA_CMD)); // R11

endmodule

bind remap_gcmd_ctrl remap_gcmd_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .cmd_err   (cmd_err),
   .inval_req (inval_req),
   .dma_en    (dma_en),
   .root_ptr  (root_ptr),
   .irt_ptr   (irt_ptr),
   .sts       (sts_q),
   .busy      (tmr_busy)
);

// File: tb/remap_gcmd_ctrl_tb.sv
module remap_gcmd_ctrl_tb;

   localparam int MAJ = 2;
   localparam int MIN = 5;
   localparam int DLY_RST = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        qi_en, dma_en, intr_en, inval_req, cmd_err;
   logic [63:0] root_ptr, irt_ptr;
   logic [3:0]  irt_size;

   int n_chk = 0;
   int n_fail = 0;
   logic [2:0] m_sts = '0;
   int cur_dly = DLY_RST;

   always #5 clk = ~clk;

   remap_gcmd_ctrl #(.DLY_RESET(DLY_RST), .VER_MAJOR(MAJ), .VER_MINOR(MIN)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .qi_en(qi_en), .dma_en(dma_en),
      .intr_en(intr_en), .root_ptr(root_ptr), .irt_ptr(irt_ptr), .irt_size(irt_size),
      .inval_req(inval_req), .cmd_err(cmd_err)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic set_dly(input int d);
      wr(3'd7, 32'(d));
      cur_dly = d;
   endtask

   task automatic change_en(input int b, input logic v);
      logic [2:0] nxt;
      logic [31:0] r;
      int lat;
      nxt = m_sts;
      nxt[b] = v;
      wr(3'd1, {29'b0, nxt});
      lat = 0;
      rd(3'd2, r);
      while (r[b] !== v && lat < 100) begin
         @(negedge clk);
         lat++;
         rd(3'd2, r);
      end
      if (v) check("R6 set latency", 64'(lat), 64'(cur_dly + 1));
      else   check("R7 clear latency", 64'(lat), 64'(cur_dly + 1));
      m_sts = nxt;
      check("R8 enables follow status", {61'b0, intr_en, dma_en, qi_en}, {61'b0, m_sts});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [31:0] r;
      logic [31:0] lo, hi;
      logic [63:0] prev;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd2, r);
      check("R1 status", {32'b0, r}, 64'd0);
      check("R1 enables", {61'b0, intr_en, dma_en, qi_en}, 64'd0);
      check("R1 root_ptr", root_ptr, 64'd0);
      check("R1 irt_ptr", {irt_ptr[63:4], irt_size}, 64'd0);
      check("R1 pulses", {62'b0, inval_req, cmd_err}, 64'd0);

      // R2 version word
      rd(3'd0, r);
      check("R2 version", {32'b0, r}, 64'((MAJ << 3) | MIN));
      check("R2 major at least one", 64'(r[6:3] >= 4'd1), 64'd1);
      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, r);
      check("R2 version after write", {32'b0, r}, 64'((MAJ << 3) | MIN));

      // R12 delay register
      rd(3'd7, r);
      check("R12 delay reset", {32'b0, r}, 64'(DLY_RST));
      for (int k = 0; k < 4; k++) begin
         wr(3'd7, 32'hABCD_0000 | 32'(k * 37 + 9));
         rd(3'd7, r);
         check("R12 delay readback", {32'b0, r}, 64'((k * 37 + 9) & 8'hFF));
      end

      // R6 R7 R8 sweep over delay and enable bit
      for (int d = 0; d < 5; d++) begin
         set_dly(d);
         for (int b = 0; b < 3; b++) begin
            change_en(b, 1'b1);
         end
         for (int b = 0; b < 3; b++) begin
            change_en(b, 1'b0);
         end
      end

      // R9 command while pending
      set_dly(6);
      wr(3'd1, 32'h1);
      wr(3'd1, 32'h2);
      check("R9 reject while pending", {63'b0, cmd_err}, 64'd1);
      repeat (10) @(negedge clk);
      rd(3'd2, r);
      check("R9 first change completes only", {32'b0, r}, 64'd1);
      m_sts = 3'b001;
      set_dly(1);

      // R3 malformed commands
      wr(3'd3, 32'h1234_5FFF);
      wr(3'd4, 32'h0000_00AB);
      prev = root_ptr;
      wr(3'd1, {29'b0, m_sts ^ 3'b110});
      check("R3 two bits", {63'b0, cmd_err}, 64'd1);
      @(negedge clk);
      check("R3 err one cycle", {63'b0, cmd_err}, 64'd0);
      wr(3'd1, {29'b0, m_sts});
      check("R3 zero bits", {63'b0, cmd_err}, 64'd1);
      wr(3'd1, {29'b0, m_sts} | 32'h400);
      check("R3 undefined bit", {63'b0, cmd_err}, 64'd1);
      wr(3'd1, {29'b0, m_sts} | 32'h30);
      check("R3 two latches", {63'b0, cmd_err}, 64'd1);
      check("R3 pointer kept", root_ptr, prev);
      repeat (4) @(negedge clk);
      rd(3'd2, r);
      check("R3 status kept", {32'b0, r}, {61'b0, m_sts});

      // R4 R5 R11 pointer sweep
      for (int i = 0; i < 6; i++) begin
         lo = (32'h1000_0FFF * 32'(i + 1)) ^ 32'h5A5A_A5A5;
         hi = 32'h0123_4567 + 32'(i) * 32'h1111_0001;
         prev = root_ptr;
         wr(3'd3, lo);
         wr(3'd4, hi);
         check("R11 root staged only", root_ptr, prev);
         wr(3'd1, {29'b0, m_sts} | 32'h10);
         check("R4 root latched masked", root_ptr, {hi, lo} & ~64'hFFF);
         check("R10 no flush when disabled", {63'b0, inval_req}, 64'd0);
         rd(3'd2, r);
         check("R4 one-shot absent from status", {32'b0, r}, {61'b0, m_sts});

         lo = (lo & 32'hFFFF_FFF0) | 32'((i * 3) % 16);
         hi = ~hi;
         prev = irt_ptr;
         wr(3'd5, lo);
         wr(3'd6, hi);
         check("R11 irt staged only", irt_ptr, prev);
         wr(3'd1, {29'b0, m_sts} | 32'h20);
         check("R5 irt latched masked", irt_ptr, {hi, lo} & ~64'hFFF);
         check("R5 size code", {60'b0, irt_size}, 64'(lo[3:0]));
      end

      // R10 latch while enabled
      change_en(1, 1'b1);
      wr(3'd3, 32'h8765_4321);
      wr(3'd1, {29'b0, m_sts} | 32'h10);
      check("R10 root flush pulse", {63'b0, inval_req}, 64'd1);
      check("R10 root still latched", root_ptr[31:0], 64'h8765_4000);
      @(negedge clk);
      check("R10 pulse one cycle", {63'b0, inval_req}, 64'd0);
      wr(3'd1, {29'b0, m_sts} | 32'h20);
      check("R10 irt no flush", {63'b0, inval_req}, 64'd0);
      change_en(2, 1'b1);
      wr(3'd1, {29'b0, m_sts} | 32'h20);
      check("R10 irt flush pulse", {63'b0, inval_req}, 64'd1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule